// File: doc/BRIEF.md
# Multi-Node Result Collection Sequencer

This block collects result blocks from up to eight processing nodes that share one address bus and one 32-bit data bus. Each node has a ready line that it raises once its results are in place. The block has one engaged line per node, which it raises while it owns that node's memory. The collector steps through a programmable list of node slots. When the node in the current slot is ready, the collector engages it and reads every address between a lower bound and an upper bound. Each word is read under that node's output enable. The collector then drops the engaged line and moves on to the next slot.

Each 32-bit word is split into two 16-bit writes to a local FIFO, low half first. A chain of counters sets the pace. An 8-bit prescaler gives the tick rate. A 3-bit micro-sequencer provides eight steps per location. An 18-bit address counter walks the range. A slot counter walks the node list. A full FIFO freezes the micro-sequencer until space appears. Software programs four registers through a simple write port.

Top module: `result_gather`

## Requirements
- R1: After reset, all engaged and output-enable lines are low, no FIFO write is issued, and the address bus reads 0. All configuration registers are 0, so the slot list holds one slot with node 0.
- R2: While idle, the collector samples one slot per tick. It engages that slot's node only when the node's ready line was high at that tick, and otherwise it moves to the next slot. At most one engaged line is high at any time.
- R3: Each location takes eight micro-steps. The address is driven from step 0. The node's output enable is high during steps 1 and 2, and never outside its engaged window. The word is latched at the tick that ends step 2, while the enable is still high.
- R4: An engaged node is read from the lower bound up to the upper bound, inclusive and in ascending order. A lower bound above the upper bound reads exactly one word, at the lower bound.
- R5: After its last address, the collector drops the engaged line and continues with the following slot. It never re-engages the same slot straight away, and it never hands the bus from one node to another in a single cycle.
- R6: Every word produces two FIFO writes, bits 15:0 first and then bits 31:16.
- R7: While the FIFO full input is high, no FIFO write is issued and the micro-sequencer holds its step. No half-word is lost or duplicated.
- R8: With rate value D, each micro-step lasts D+1 cycles. The two writes of one word are D+1 cycles apart. The first writes of consecutive locations are 8(D+1) cycles apart.
- R9: In the order register, bits [3k+2:3k] hold the node index of slot k. Bits [26:24] hold the number of slots minus one. Slots beyond that count are never visited, and a ready node absent from the list is never engaged.
- R10: A write with select 0 loads the lower bound (bits 17:0). Select 1 loads the upper bound (bits 17:0). Select 2 loads the rate value (bits 7:0). Select 3 loads the order register.
- R11: When no listed node is ready, collection is suspended: no engaged line, no output enable and no FIFO write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 lower, 1 upper, 2 rate, 3 order |
| cfg_wdata | input | 32 | Register write data |
| node_ready | input | 8 | Per-node results-ready lines |
| node_engaged | output | 8 | Per-node engaged lines driven by the collector |
| node_oe | output | 8 | Per-node memory output enables |
| res_addr | output | 18 | Shared result address bus |
| res_data | input | 32 | Shared result data bus |
| fifo_full | input | 1 | FIFO full flag; stalls writes |
| fifo_wr | output | 1 | FIFO write strobe, one cycle per half-word |
| fifo_wdata | output | 16 | FIFO write data |

## Verification
Some properties are checked on every cycle. These are the bus-ownership rules: a single engaged line, enables only inside the engaged window, a steady address under an enable, and an address held within the bounds. They also cover engagement only after a ready sample, no direct hand-over between nodes, and no write while the FIFO is full or the block is idle. Other behaviour only the scenarios can show. This covers the slot order and the skipping of unlisted or duplicate nodes, the exact half-word stream and its low-then-high order, the single-word reverse range, loss-free recovery from long full stalls, and the measured spacing of writes under a nonzero rate value.

// File: rtl/rg_pkg.sv
package rg_pkg;

   typedef enum logic {
      PH_POLL = 1'b0,
      PH_XFER = 1'b1
   } phase_t;

   typedef logic [2:0] step_t;

   // micro-step decode for one location
   localparam step_t ST_ADDR = 3'd0;  // address driven
   localparam step_t ST_OE_A = 3'd1;  // enable raised
   localparam step_t ST_OE_B = 3'd2;  // enable held, word latched at end
   localparam step_t ST_REL  = 3'd3;  // enable released
   localparam step_t ST_WLO  = 3'd4;  // low half to FIFO
   localparam step_t ST_WHI  = 3'd5;  // high half to FIFO
   localparam step_t ST_GAP  = 3'd6;  // spacer
   localparam step_t ST_NEXT = 3'd7;  // address advance or finish

   localparam logic [1:0] SEL_LOWER = 2'd0;
   localparam logic [1:0] SEL_UPPER = 2'd1;
   localparam logic [1:0] SEL_RATE  = 2'd2;
   localparam logic [1:0] SEL_ORDER = 2'd3;

endpackage

// File: rtl/rg_prescaler.sv
module rg_prescaler #(
   parameter int RATE_W = 8,
   localparam int RW    = (RATE_W > 0) ? RATE_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] div,
   output logic          tick
);

   generate
      if (RATE_W == 0) begin : g_free
         logic unused_div;
         assign unused_div = ^div;
         assign tick = 1'b1;
      end else begin : g_count
         logic [RW-1:0] cnt_q;
         assign tick = (cnt_q >= div);
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + RW'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/rg_step_seq.sv
module rg_step_seq
   import rg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  logic  tick,
   input  logic  hold,
   output step_t step,
   output logic  carry
);

   step_t step_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              step_q <= ST_ADDR;
      else if (!run)           step_q <= ST_ADDR;
      else if (tick && !hold)  step_q <= step_q + step_t'(1);
   end

   assign step  = step_q;
   assign carry = run && tick && !hold && (step_q == ST_NEXT);

endmodule

// File: rtl/rg_addr_walker.sv
module rg_addr_walker #(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [ADDR_W-1:0] lower,
   input  logic [ADDR_W-1:0] upper,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              addr_q <= '0;
      else if (load)           addr_q <= lower;
      else if (adv && !at_end) addr_q <= addr_q + ADDR_W'(1);
   end

   assign addr   = addr_q;
   assign at_end = (addr_q >= upper);

endmodule

// File: rtl/rg_node_order.sv
module rg_node_order #(
   parameter int NODES   = 8,
   localparam int SW     = (NODES > 1) ? $clog2(NODES) : 1,
   localparam int ORDER_W = (NODES + 1) * SW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ORDER_W-1:0] order_word,
   input  logic               adv,
   output logic [SW-1:0]      cur_node
);

   logic [SW-1:0] slot_node [NODES];
   logic [SW-1:0] last_raw;
   logic [SW-1:0] last_idx;
   logic [SW-1:0] slot_q;

   generate
      for (genvar g = 0; g < NODES; g++) begin : g_slot
         assign slot_node[g] = order_word[g*SW +: SW];
      end
   endgenerate

   assign last_raw = order_word[NODES*SW +: SW];
   assign last_idx = (last_raw > SW'(NODES - 1)) ? SW'(NODES - 1) : last_raw;

   always_ff @(posedge clk) begin
      if (!rst_n)   slot_q <= '0;
      else if (adv) slot_q <= (slot_q >= last_idx) ? '0 : slot_q + SW'(1);
   end

   assign cur_node = slot_node[slot_q];

endmodule

// File: rtl/result_gather.sv
module result_gather
   import rg_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int ADDR_W = 18,
   parameter int DATA_W = 32,
   parameter int RATE_W = 8,
   parameter int CFG_W  = 32,
   localparam int HALF_W  = DATA_W / 2,
   localparam int SW      = (NODES > 1) ? $clog2(NODES) : 1,
   localparam int ORDER_W = (NODES + 1) * SW,
   localparam int RW      = (RATE_W > 0) ? RATE_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [NODES-1:0]  node_ready,
   output logic [NODES-1:0]  node_engaged,
   output logic [NODES-1:0]  node_oe,
   output logic [ADDR_W-1:0] res_addr,
   input  logic [DATA_W-1:0] res_data,
   input  logic              fifo_full,
   output logic              fifo_wr,
   output logic [HALF_W-1:0] fifo_wdata
);

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("DATA_W must be even");
      end
      if (NODES < 1) begin : g_bad_nodes
         $error("NODES must be at least 1");
      end
      if (ADDR_W > CFG_W || RW > CFG_W || ORDER_W > CFG_W) begin : g_bad_cfg
         $error("a register field does not fit in CFG_W");
      end
   endgenerate

   // configuration registers
   logic [ADDR_W-1:0]  lower_q, upper_q;
   logic [RW-1:0]      rate_q;
   logic [ORDER_W-1:0] order_q;
   logic               unused_cfg;

   assign unused_cfg = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lower_q <= '0;
         upper_q <= '0;
         rate_q  <= '0;
         order_q <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_LOWER: lower_q <= cfg_wdata[ADDR_W-1:0];
            SEL_UPPER: upper_q <= cfg_wdata[ADDR_W-1:0];
            SEL_RATE:  rate_q  <= cfg_wdata[RW-1:0];
            default:   order_q <= cfg_wdata[ORDER_W-1:0];
         endcase
      end
   end

   // counter chain
   logic          tick, carry, hold, at_end;
   logic          in_xfer, write_step;
   logic          poll_hit, poll_miss, last_word, slot_adv;
   step_t         step;
   logic [SW-1:0] cur_node;
   phase_t        phase_q;
   logic [DATA_W-1:0] word_q;

   rg_prescaler #(.RATE_W(RATE_W)) u_prescale (
      .clk(clk), .rst_n(rst_n), .div(rate_q), .tick(tick)
   );

   rg_step_seq u_step (
      .clk(clk), .rst_n(rst_n), .run(in_xfer), .tick(tick), .hold(hold),
      .step(step), .carry(carry)
   );

   rg_addr_walker #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(poll_hit), .adv(carry),
      .lower(lower_q), .upper(upper_q), .addr(res_addr), .at_end(at_end)
   );

   rg_node_order #(.NODES(NODES)) u_order (
      .clk(clk), .rst_n(rst_n), .order_word(order_q), .adv(slot_adv),
      .cur_node(cur_node)
   );

   // handshake control
   assign in_xfer    = (phase_q == PH_XFER);
   assign write_step = (step == ST_WLO) || (step == ST_WHI);
   assign hold       = write_step && fifo_full;
   assign poll_hit   = !in_xfer && tick && node_ready[cur_node];
   assign poll_miss  = !in_xfer && tick && !node_ready[cur_node];
   assign last_word  = carry && at_end;
   assign slot_adv   = poll_miss || last_word;

   always_ff @(posedge clk) begin
      if (!rst_n)         phase_q <= PH_POLL;
      else if (poll_hit)  phase_q <= PH_XFER;
      else if (last_word) phase_q <= PH_POLL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                  word_q <= '0;
      else if (in_xfer && tick && step == ST_OE_B) word_q <= res_data;
   end

   generate
      for (genvar g = 0; g < NODES; g++) begin : g_node
         assign node_engaged[g] = in_xfer && (cur_node == SW'(g));
         assign node_oe[g]      = node_engaged[g] &&
                                  ((step == ST_OE_A) || (step == ST_OE_B));
      end
   endgenerate

   assign fifo_wr    = in_xfer && tick && write_step && !fifo_full;
   assign fifo_wdata = (step == ST_WHI) ? word_q[DATA_W-1:HALF_W] : word_q[HALF_W-1:0];

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
   parameter int NODES  = 8,
   parameter int ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NODES-1:0]  node_ready,
   input logic [NODES-1:0]  node_engaged,
   input logic [NODES-1:0]  node_oe,
   input logic [ADDR_W-1:0] res_addr,
   input logic              fifo_full,
   input logic              fifo_wr,
   input logic [ADDR_W-1:0] lower_q,
   input logic [ADDR_W-1:0] upper_q
);

   a_r2_single_engaged: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(node_engaged));

   a_r2_engage_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (node_engaged & ~$past(node_engaged) & ~$past(node_ready)) == '0);

   a_r3_oe_inside_engaged: assert property (@(posedge clk) disable iff (!rst_n)
      (node_oe & ~node_engaged) == '0);

   a_r3_addr_steady_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (|(node_oe & $past(node_oe))) |-> $stable(res_addr));

   a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (|node_oe) |-> ((res_addr == lower_q) ||
                      (res_addr >= lower_q && res_addr <= upper_q)));

   a_r5_no_direct_handover: assert property (@(posedge clk) disable iff (!rst_n)
      ((|node_engaged) && (|$past(node_engaged))) |-> (node_engaged == $past(node_engaged)));

   a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !fifo_wr);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|node_engaged) |-> (!fifo_wr && node_oe == '0));

endmodule

bind result_gather rg_checker #(.NODES(NODES), .ADDR_W(ADDR_W)) u_rg_checker (
   .clk(clk), .rst_n(rst_n), .node_ready(node_ready), .node_engaged(node_engaged),
   .node_oe(node_oe), .res_addr(res_addr), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
   .lower_q(lower_q), .upper_q(upper_q)
);

// File: tb/result_gather_bench.sv
module result_gather_bench;

   localparam int NODES  = 8;
   localparam int ADDR_W = 18;
   localparam int DATA_W = 32;
   localparam int RATE_W = 8;
   localparam int CFG_W  = 32;
   localparam int HW     = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic [NODES-1:0]  node_ready = '0;
   logic [NODES-1:0]  node_engaged, node_oe;
   logic [ADDR_W-1:0] res_addr;
   logic [DATA_W-1:0] res_data;
   logic              fifo_full = 1'b0;
   logic              fifo_wr;
   logic [HW-1:0]     fifo_wdata;

   result_gather #(.NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .RATE_W(RATE_W), .CFG_W(CFG_W)) u_result_gather (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .node_ready(node_ready), .node_engaged(node_engaged),
      .node_oe(node_oe), .res_addr(res_addr), .res_data(res_data),
      .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
   );

   int checks = 0;
   int errors = 0;

   function automatic logic [31:0] word_of(int n, logic [ADDR_W-1:0] a);
      return (32'h9E37_79B9 * (32'(a) + 32'd1)) ^ (32'(n) << 28) ^ 32'h0000_1357;
   endfunction

   // node memories: data appears only under that node's enable
   always_comb begin
      res_data = 32'hDEAD_BEEF;
      for (int n = 0; n < NODES; n++)
         if (node_oe[n]) res_data = word_of(n, res_addr);
   end

   // FIFO full pattern
   int full_pct = 0;
   bit full_force = 1'b0;
   always @(posedge clk) begin
      #1;
      fifo_full = full_force || (full_pct > 0 && ($urandom % 100) < full_pct);
   end

   // monitor
   logic [NODES-1:0] eng_prev = '0;
   bit auto_drop = 1'b1;
   int visit [0:63];
   int nvisit = 0;
   logic [HW-1:0] got [0:4095];
   int got_cyc [0:4095];
   int ngot = 0;
   int cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         for (int n = 0; n < NODES; n++) begin
            if (node_engaged[n] && !eng_prev[n] && nvisit < 64) begin
               visit[nvisit] = n;
               nvisit++;
            end
            if (!node_engaged[n] && eng_prev[n] && auto_drop) node_ready[n] = 1'b0;
         end
         if (fifo_wr && ngot < 4096) begin
            got[ngot] = fifo_wdata;
            got_cyc[ngot] = cyc;
            ngot++;
         end
      end
      eng_prev = node_engaged;
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cfg_we = 1'b0;
      node_ready = '0;
      full_force = 1'b0;
      full_pct = 0;
      auto_drop = 1'b1;
      repeat (3) @(posedge clk);
      nvisit = 0;
      ngot = 0;
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs after reset
      chk(node_engaged == '0 && node_oe == '0 && !fifo_wr && res_addr == '0, "R1",
          "reset outputs", {node_engaged, node_oe, fifo_wr, 14'(res_addr)}, 0);
   endtask

   task automatic cfg_write(logic [1:0] sel, logic [CFG_W-1:0] data);
      @(posedge clk);
      #1;
      cfg_we = 1'b1;
      cfg_sel = sel;
      cfg_wdata = data;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   // R10: register map used for every configuration
   task automatic configure(int cnt_m1, int list[8], int lo, int hi, int div);
      logic [31:0] ord = '0;
      for (int k = 0; k < 8; k++) ord |= 32'(list[k] & 7) << (3 * k);
      ord |= 32'(cnt_m1 & 7) << 24;
      cfg_write(2'd0, 32'(lo));
      cfg_write(2'd1, 32'(hi));
      cfg_write(2'd2, 32'(div));
      cfg_write(2'd3, ord);
   endtask

   task automatic run_scenario(string tag, int cnt_m1, int list[8], logic [7:0] rmask,
                               int lo, int hi, int div, int pct, int stall_cyc);
      int exp_v[0:7];
      int nexp = 0;
      logic [7:0] listed = '0;
      logic [7:0] seen = '0;
      logic [HW-1:0] exp_h[0:4095];
      int nexp_h = 0;
      int t = 0;
      int mism = -1;
      int idle_base;
      bit idle_bad = 1'b0;
      bit vis_ok;
      do_reset();
      configure(cnt_m1, list, lo, hi, div);
      for (int k = 0; k <= cnt_m1; k++) begin
         listed[list[k]] = 1'b1;
         if (rmask[list[k]] && !seen[list[k]]) begin
            seen[list[k]] = 1'b1;
            exp_v[nexp] = list[k];
            nexp++;
         end
      end
      for (int i = 0; i < nexp; i++) begin
         logic [ADDR_W-1:0] a = ADDR_W'(lo);
         forever begin
            logic [31:0] w = word_of(exp_v[i], a);
            exp_h[nexp_h] = w[15:0];
            exp_h[nexp_h + 1] = w[31:16];
            nexp_h += 2;
            if (a >= ADDR_W'(hi)) break;
            a++;
         end
      end
      full_force = (stall_cyc > 0);
      full_pct = pct;
      node_ready = rmask;
      if (stall_cyc > 0) begin
         repeat (stall_cyc) @(negedge clk);
         // R7: nothing written while full, node kept engaged
         chk(ngot == 0, "R7", {tag, " writes during full"}, ngot, 0);
         chk(node_engaged == 8'(1 << exp_v[0]), "R7", {tag, " engaged during stall"},
             node_engaged, 1 << exp_v[0]);
         full_force = 1'b0;
      end
      while ((node_ready & listed) != '0 && t < 20000) begin
         @(negedge clk);
         t++;
      end
      full_pct = 0;
      // R11: suspended once no listed node is ready
      idle_base = ngot;
      repeat (100) begin
         @(negedge clk);
         if (node_engaged != '0 || node_oe != '0) idle_bad = 1'b1;
      end
      chk(!idle_bad && ngot == idle_base, "R11", {tag, " idle activity"},
          ngot - idle_base, 0);
      // R2 / R9: visit order follows the slot list, ready nodes only
      vis_ok = (nvisit == nexp);
      for (int i = 0; i < nexp && i < nvisit; i++) if (visit[i] != exp_v[i]) vis_ok = 1'b0;
      chk(vis_ok, "R2", {tag, " visit sequence length/order"}, nvisit, nexp);
      chk((node_ready & rmask & ~listed) == (rmask & ~listed), "R9",
          {tag, " unlisted ready node touched"}, node_ready, rmask & ~listed);
      // R6 / R4: half-word stream
      chk(ngot == nexp_h, "R6", {tag, " half-word count"}, ngot, nexp_h);
      for (int i = 0; i < ngot && i < nexp_h; i++)
         if (mism < 0 && got[i] !== exp_h[i]) mism = i;
      chk(mism < 0, "R3", {tag, " half-word content"},
          (mism < 0) ? 0 : got[mism], (mism < 0) ? 0 : exp_h[mism]);
   endtask

   initial begin
      int l[8];
      void'($urandom(32'h0005_EED5));

      // R9 / R2: full list in reverse order, all ready
      l = '{7, 6, 5, 4, 3, 2, 1, 0};
      run_scenario("reverse", 7, l, 8'hFF, 40, 42, 0, 0, 0);

      // R8: rate spacing
      l = '{6, 0, 0, 0, 0, 0, 0, 0};
      run_scenario("rate", 0, l, 8'h40, 10, 12, 5, 0, 0);
      chk(ngot >= 3 && got_cyc[1] - got_cyc[0] == 6, "R8", "low-to-high spacing",
          got_cyc[1] - got_cyc[0], 6);
      chk(ngot >= 3 && got_cyc[2] - got_cyc[0] == 48, "R8", "location spacing",
          got_cyc[2] - got_cyc[0], 48);
      chk(got[0] == word_of(6, 10) % 65536, "R6", "low half first", got[0],
          word_of(6, 10) % 65536);

      // R4: reversed bounds give one word
      l = '{0, 3, 0, 0, 0, 0, 0, 0};
      run_scenario("revbound", 1, l, 8'h08, 20, 5, 0, 0, 0);
      chk(ngot == 2, "R4", "single word for lower>upper", ngot, 2);

      // R7: long full stall then release
      l = '{2, 0, 0, 0, 0, 0, 0, 0};
      run_scenario("stall", 0, l, 8'h04, 100, 101, 0, 0, 200);

      // R9: unlisted ready node ignored, duplicates visited once
      l = '{3, 5, 0, 0, 0, 0, 0, 0};
      run_scenario("unlisted", 1, l, 8'h68, 7, 9, 1, 0, 0);
      l = '{2, 2, 4, 0, 0, 0, 0, 0};
      run_scenario("dup", 2, l, 8'h14, 262140, 262143, 0, 0, 0);

      // R11: nothing listed is ready
      l = '{1, 2, 0, 0, 0, 0, 0, 0};
      run_scenario("none", 1, l, 8'h01, 0, 3, 0, 0, 0);

      // R5: ready never drops, slots alternate
      do_reset();
      auto_drop = 1'b0;
      l = '{1, 4, 0, 0, 0, 0, 0, 0};
      configure(1, l, 7, 7, 1);
      node_ready = 8'h12;
      for (int t = 0; t < 5000 && nvisit < 4; t++) @(negedge clk);
      chk(nvisit >= 4 && visit[0] == 1 && visit[1] == 4 && visit[2] == 1 && visit[3] == 4,
          "R5", "slot advance after finish", nvisit >= 4 ? visit[2] : -1, 1);
      node_ready = '0;

      // random mix
      for (int s = 0; s < 20; s++) begin
         int cnt = $urandom % 8;
         int lo = $urandom % 262000;
         int hi = lo + ($urandom % 5);
         int lr[8];
         if ($urandom % 10 == 0) hi = lo - 1 - ($urandom % 3);
         for (int k = 0; k < 8; k++) lr[k] = $urandom % 8;
         run_scenario($sformatf("rand%0d", s), cnt, lr, 8'($urandom), lo, hi,
                      $urandom % 4, ($urandom % 2) ? 30 : 0, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule